// File: doc/BRIEF.md
# Receive byte order aligner

This block sits behind the byte deserializer on a receive path that carries two byte lanes per word. It looks for a configurable pattern byte in the stream of words. When the pattern shows up in the upper lane, the block adds one configurable PAD byte to the stream. From then on, every byte is moved down by one lane, so the pattern and everything after it arrive with the pattern in the least significant lane. When the pattern already arrives in the low lane, the lanes stay as they are and the block only records that ordering is done. Each byte has a control (K) flag that moves together with it.

A static mode input chooses how a search is started.

- **Sync-status mode:** the block orders once per reset, on the first pattern seen after the word aligner reports sync.
- **Dynamic mode:** a user request can start a new search at any time.

The output is registered, with one cycle of latency. A one-cycle pulse marks the word that holds the PAD. A sticky status bit reports that ordering is complete.

Top module: `rx_byte_order_aligner`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all outputs are 0 and the lanes are straight: no shift and no held byte in use.
- R2: A valid input word appears on `out_data`/`out_k` one clock later. In straight alignment the word passes unchanged: bits 7:0 are the low lane and are earlier in the stream, bits 15:8 are the high lane.
- R3: Suppose a search is active, the lanes are straight, and the pattern is in the high lane but not the low lane of a valid word. That output word is then {PAD, low byte}, with `cfg_pad_k` as its high-lane K flag, and `pad_inserted` is 1 for that word only. In every later valid word, the low lane is the previous word's high byte and the high lane is the current low byte.
- R4: Suppose a search is active and the low lane of a valid word equals the pattern. No PAD is inserted, the alignment becomes or stays straight, and ordering completes. The low lane wins when both lanes match.
- R5: Each K flag stays with its own byte through the pass-through, PAD-insertion and shifted paths.
- R6: `order_done` becomes 1 with the output word in which the pattern was found. It then stays at 1 until `rst`. In dynamic mode, a request without a find in the same cycle clears it instead.
- R7: In sync-status mode (`cfg_dyn_mode`=0), a search is active only while `sync_status`=1 and ordering is not yet done. Patterns arriving at other times, and `order_req`, have no effect on the output words.
- R8: In dynamic mode (`cfg_dyn_mode`=1), `order_req`=1 starts a search that stays pending until a pattern is found. The search is active in the request cycle itself, and `sync_status` is ignored. A find in the high lane while already shifted keeps the shift and inserts no PAD. A find in the low lane while shifted returns the lanes to straight, and the held byte is discarded.
- R9: An input word with `in_valid`=0 makes `out_valid`=0 and `pad_inserted`=0 in the next cycle. `out_data`/`out_k` keep their values, and the alignment and held byte stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rst | input | 1 | Synchronous receive digital reset, active high |
| cfg_dyn_mode | input | 1 | Static arming source: 0 sync status, 1 user request |
| cfg_pattern | input | 8 | Byte-order pattern byte |
| cfg_pad | input | 8 | PAD byte to insert |
| cfg_pad_k | input | 1 | K flag sent with the PAD byte |
| sync_status | input | 1 | Word-aligner sync indication |
| order_req | input | 1 | Dynamic ordering request |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | 16 | Input word, low lane in bits 7:0 |
| in_k | input | 2 | Input K flags, bit n for lane n |
| out_valid | output | 1 | Output word qualifier |
| out_data | output | 16 | Reordered word, low lane in bits 7:0 |
| out_k | output | 2 | Reordered K flags |
| pad_inserted | output | 1 | Pulse: this output word carries the PAD |
| order_done | output | 1 | Sticky: byte ordering complete |

## Verification
The assertions assume that `cfg_dyn_mode`, `cfg_pattern`, `cfg_pad` and `cfg_pad_k` hold steady outside reset. They also assume that `rst` is applied after a configuration change. The stimulus follows this by changing configuration only inside a reset window. Data bytes are drawn from a mix in which about a quarter are the pattern, so finds in the low lane, the high lane and both lanes all occur. Invalid words, requests and sync toggles are scattered at random among them.

// File: rtl/rbo_pkg.sv
package rbo_pkg;

  typedef enum logic {
    ALIGN_STRAIGHT = 1'b0,
    ALIGN_SHIFTED  = 1'b1
  } align_e;

  // Alignment after a word: a find sets it from the lane of the hit,
  // otherwise the current alignment is kept.
  function automatic align_e next_align(align_e cur, logic found, logic low_hit);
    if (!found) return cur;
    return low_hit ? ALIGN_STRAIGHT : ALIGN_SHIFTED;
  endfunction

  // A PAD is inserted only when moving from straight into shifted.
  function automatic logic pad_needed(align_e cur, logic found, logic low_hit);
    return found && !low_hit && (cur == ALIGN_STRAIGHT);
  endfunction

endpackage

// File: rtl/rbo_match.sv
module rbo_match #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic [LANES*LANE_W-1:0] word,
  input  logic [LANE_W-1:0]       pattern,
  output logic [LANES-1:0]        hit
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit[g] = (word[g*LANE_W +: LANE_W] == pattern);
  end
endmodule

// File: rtl/rbo_arm.sv
module rbo_arm (
  input  logic clk,
  input  logic rst,
  input  logic dyn_mode,
  input  logic sync_status,
  input  logic order_req,
  input  logic found,
  output logic search_active,
  output logic done
);
  logic pend_q;
  logic done_q;

  always_comb begin
    if (dyn_mode) search_active = pend_q | order_req;
    else          search_active = sync_status & ~done_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (found) begin
      pend_q <= 1'b0;
      done_q <= 1'b1;
    end else if (dyn_mode && order_req) begin
      pend_q <= 1'b1;
      done_q <= 1'b0;
    end
  end

  assign done = done_q;
endmodule

// File: rtl/rbo_lane_shift.sv
module rbo_lane_shift
  import rbo_pkg::*;
#(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [2*LANE_W-1:0] in_data,
  input  logic [1:0]          in_k,
  input  logic                found,
  input  logic                low_hit,
  input  logic [LANE_W-1:0]   pad_byte,
  input  logic                pad_k,
  output logic                out_valid,
  output logic [2*LANE_W-1:0] out_data,
  output logic [1:0]          out_k,
  output logic                pad_pulse,
  output logic                shifted
);
  align_e              align_q, align_n;
  logic [LANE_W-1:0]   hold_q;
  logic                hold_k_q;
  logic                pad_now;
  logic [LANE_W-1:0]   lo_b, hi_b;
  logic                lo_k, hi_k;
  logic [LANE_W-1:0]   in_lo, in_hi;

  assign in_lo = in_data[LANE_W-1:0];
  assign in_hi = in_data[2*LANE_W-1:LANE_W];

  always_comb begin
    align_n = next_align(align_q, found, low_hit);
    pad_now = pad_needed(align_q, found, low_hit);
    if (align_n == ALIGN_STRAIGHT) begin
      lo_b = in_lo;     lo_k = in_k[0];
      hi_b = in_hi;     hi_k = in_k[1];
    end else if (pad_now) begin
      lo_b = in_lo;     lo_k = in_k[0];
      hi_b = pad_byte;  hi_k = pad_k;
    end else begin
      lo_b = hold_q;    lo_k = hold_k_q;
      hi_b = in_lo;     hi_k = in_k[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      align_q   <= ALIGN_STRAIGHT;
      hold_q    <= '0;
      hold_k_q  <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_k     <= '0;
      pad_pulse <= 1'b0;
    end else begin
      out_valid <= in_valid;
      pad_pulse <= in_valid & pad_now;
      if (in_valid) begin
        align_q  <= align_n;
        hold_q   <= in_hi;
        hold_k_q <= in_k[1];
        out_data <= {hi_b, lo_b};
        out_k    <= {hi_k, lo_k};
      end
    end
  end

  assign shifted = (align_q == ALIGN_SHIFTED);
endmodule

// File: rtl/rx_byte_order_aligner.sv
module rx_byte_order_aligner #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_dyn_mode,
  input  logic [LANE_W-1:0]   cfg_pattern,
  input  logic [LANE_W-1:0]   cfg_pad,
  input  logic                cfg_pad_k,
  input  logic                sync_status,
  input  logic                order_req,
  input  logic                in_valid,
  input  logic [2*LANE_W-1:0] in_data,
  input  logic [1:0]          in_k,
  output logic                out_valid,
  output logic [2*LANE_W-1:0] out_data,
  output logic [1:0]          out_k,
  output logic                pad_inserted,
  output logic                order_done
);
  localparam int LANES = 2;

  logic [LANES-1:0] hit;
  logic             hit_lo;
  logic             search_active;
  logic             found;
  logic             shifted;

  rbo_match #(.LANE_W(LANE_W), .LANES(LANES)) u_match (
    .word    (in_data),
    .pattern (cfg_pattern),
    .hit     (hit)
  );

  assign hit_lo = hit[0];
  assign found  = in_valid & search_active & (|hit);

  rbo_arm u_arm (
    .clk           (clk),
    .rst           (rst),
    .dyn_mode      (cfg_dyn_mode),
    .sync_status   (sync_status),
    .order_req     (order_req),
    .found         (found),
    .search_active (search_active),
    .done          (order_done)
  );

  rbo_lane_shift #(.LANE_W(LANE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_k      (in_k),
    .found     (found),
    .low_hit   (hit_lo),
    .pad_byte  (cfg_pad),
    .pad_k     (cfg_pad_k),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_k     (out_k),
    .pad_pulse (pad_inserted),
    .shifted   (shifted)
  );
endmodule

// File: rtl/rbo_checker.sv
module rbo_checker #(
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                cfg_dyn_mode,
  input logic [LANE_W-1:0]   cfg_pattern,
  input logic [LANE_W-1:0]   cfg_pad,
  input logic                cfg_pad_k,
  input logic                in_valid,
  input logic [2*LANE_W-1:0] out_data,
  input logic                out_valid,
  input logic [1:0]          out_k,
  input logic                pad_inserted,
  input logic                order_done,
  input logic                found,
  input logic                hit_lo,
  input logic                shifted
);
  AST_PAD_WORD_UPPER: assert property (@(posedge clk) disable iff (rst)
    pad_inserted |-> (out_valid && out_data[2*LANE_W-1:LANE_W] == cfg_pad && out_k[1] == cfg_pad_k)); // R3

  AST_PAD_FROM_STRAIGHT: assert property (@(posedge clk) disable iff (rst)
    pad_inserted |-> $past(found && !hit_lo && !shifted)); // R3

  AST_LOW_HIT_ALIGNS: assert property (@(posedge clk) disable iff (rst)
    (found && hit_lo) |=> (out_valid && out_data[LANE_W-1:0] == cfg_pattern && !pad_inserted && !shifted)); // R4

  AST_HIGH_HIT_SHIFTS: assert property (@(posedge clk) disable iff (rst)
    (found && !hit_lo) |=> (shifted && out_valid)); // R8

  AST_DONE_ON_FIND: assert property (@(posedge clk) disable iff (rst)
    found |=> order_done); // R6

  AST_SYNC_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!cfg_dyn_mode && order_done) |=> order_done); // R7

  AST_INVALID_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !pad_inserted && $stable(out_data) && $stable(out_k) && $stable(shifted))); // R9
endmodule

bind rx_byte_order_aligner rbo_checker #(.LANE_W(LANE_W)) u_chk (.*);

// File: tb/rx_byte_order_aligner_test.sv
`timescale 1ns/100ps
module rx_byte_order_aligner_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_dyn_mode = 1'b0;
  logic [7:0]  cfg_pattern = 8'hBC;
  logic [7:0]  cfg_pad = 8'h9C;
  logic        cfg_pad_k = 1'b1;
  logic        sync_status = 1'b0;
  logic        order_req = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  in_k = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [1:0]  out_k;
  logic        pad_inserted;
  logic        order_done;

  int checks = 0;
  int errors = 0;

  // reference state
  logic       m_shift, m_hk, m_done, m_pend;
  logic [7:0] m_hold;
  logic       e_valid, e_pad;
  logic [15:0] e_data;
  logic [1:0]  e_k;

  always #2.5 clk = ~clk;

  rx_byte_order_aligner uut (.*);

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pick_byte(input logic [7:0] pat);
    return ($urandom % 4 == 0) ? pat : 8'($urandom);
  endfunction

  task automatic model_clear();
    m_shift = 0; m_hold = 0; m_hk = 0; m_done = 0; m_pend = 0;
    e_valid = 0; e_pad = 0; e_data = 0; e_k = 0;
  endtask

  // Reference behaviour written from the requirements
  task automatic model_step(input logic v, input logic [15:0] d, input logic [1:0] k,
                            input logic s, input logic r);
    logic act, hlo, hhi, det;
    act = cfg_dyn_mode ? (m_pend | r) : (s & ~m_done);
    hlo = (d[7:0] == cfg_pattern);
    hhi = (d[15:8] == cfg_pattern);
    det = v && act && (hlo || hhi);
    e_valid = v;
    e_pad = 0;
    if (v) begin
      if (det && hlo) begin
        m_shift = 0;
      end else if (det && !m_shift) begin
        e_pad = 1;
        m_shift = 1;
        e_data = {cfg_pad, d[7:0]};
        e_k = {cfg_pad_k, k[0]};
      end
      if (!m_shift) begin
        e_data = d; e_k = k;
      end else if (!e_pad) begin
        e_data = {d[7:0], m_hold}; e_k = {k[0], m_hk};
      end
      m_hold = d[15:8]; m_hk = k[1];
    end
    if (det) begin
      m_done = 1; m_pend = 0;
    end else if (cfg_dyn_mode && r) begin
      m_done = 0; m_pend = 1;
    end
  endtask

  task automatic step(input logic v, input logic [15:0] d, input logic [1:0] k,
                      input logic s, input logic r, input string tag);
    in_valid = v; in_data = d; in_k = k; sync_status = s; order_req = r;
    model_step(v, d, k, s, r);
    @(negedge clk);
    check(tag, "out_valid", 32'(out_valid), 32'(e_valid));
    check(tag, "out_data", 32'(out_data), 32'(e_data));
    check(tag, "out_k", 32'(out_k), 32'(e_k));
    check(tag, "pad_inserted", 32'(pad_inserted), 32'(e_pad));
    check(tag, "order_done", 32'(order_done), 32'(m_done));
  endtask

  task automatic do_reset(input logic dyn);
    rst = 1; in_valid = 0; order_req = 0; sync_status = 0;
    cfg_dyn_mode = dyn;
    repeat (2) @(negedge clk);
    model_clear();
    check("R1", "rst out_valid", 32'(out_valid), 0);
    check("R1", "rst out_data", 32'(out_data), 0);
    check("R1", "rst pad/done", 32'({pad_inserted, order_done, out_k}), 0);
    rst = 0;
  endtask

  task automatic random_run(input int n, input logic dyn, input string tag);
    logic s = 0;
    for (int i = 0; i < n; i++) begin
      logic v, r;
      v = ($urandom % 5) != 0;
      r = dyn && ($urandom % 23 == 0);
      if ($urandom % 17 == 0) s = ~s;
      step(v, {pick_byte(cfg_pattern), pick_byte(cfg_pattern)}, 2'($urandom), s, r, tag);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset(1'b0);
    // sync mode, no sync yet: pattern ignored
    step(1, 16'hBC11, 2'b10, 0, 1, "R7");
    step(1, 16'h2233, 2'b00, 0, 0, "R7");
    // sync asserted, high-lane pattern: PAD inserted
    step(1, 16'hBC44, 2'b10, 1, 0, "R3");
    step(1, 16'h6655, 2'b01, 1, 0, "R3");
    step(0, 16'hBCBC, 2'b11, 1, 0, "R9");
    step(1, 16'h8877, 2'b10, 1, 0, "R5");
    // later pattern in low lane ignored
    step(1, 16'h99BC, 2'b01, 1, 0, "R7");
    step(1, 16'hAABB, 2'b00, 1, 0, "R7");
    random_run(400, 1'b0, "R2");

    do_reset(1'b0);
    step(1, 16'hBCBC, 2'b11, 1, 0, "R4");
    step(1, 16'h1234, 2'b00, 1, 0, "R4");
    step(1, 16'hBC00, 2'b00, 1, 0, "R7");

    do_reset(1'b1);
    step(1, 16'hBC01, 2'b00, 1, 0, "R8");
    step(1, 16'h0203, 2'b00, 0, 1, "R8");
    step(1, 16'hBC04, 2'b10, 0, 0, "R3");
    step(1, 16'h0506, 2'b01, 0, 0, "R5");
    step(0, 16'h0000, 2'b00, 0, 1, "R6");
    step(1, 16'hBC07, 2'b00, 0, 0, "R8");
    step(1, 16'h0809, 2'b00, 0, 1, "R8");
    step(1, 16'h0ABC, 2'b00, 0, 0, "R8");
    step(1, 16'h0B0C, 2'b00, 0, 0, "R2");
    random_run(3000, 1'b1, "R8");

    for (int j = 0; j < 6; j++) begin
      do_reset(1'(j % 2));
      random_run(500, 1'(j % 2), "R6");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule